// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block places incoming frames into memory buffers under the control of a ring of receive descriptors that it keeps in a small internal table. Frames arrive as a byte stream: a valid strobe, a start-of-frame marker on the first byte, an end-of-frame marker and an upstream error flag on the last byte. For each accepted frame, the block writes the bytes out on a byte-wide buffer write port. The address of each byte is the buffer address held in the current descriptor plus the byte's offset. When the last byte arrives, the block writes the frame length and the status back into the descriptor, hands the descriptor back to software and moves on to the next one.

Software owns the descriptor table through a word-addressed register port. It arms a descriptor by setting the empty flag, marks the last descriptor of the ring with the wrap flag, and starts the engine by writing the activation register. If a frame arrives while the current descriptor is still owned by software, the block drops the frame and stops. It stays stopped until software writes the activation register again. When a good frame completes, a sticky event bit is set. Software clears it by writing a 1 to it.

Top module: `rxr_ring_ctrl`

## Requirements
- R1: After reset, the enable bit, the activation state, the event bit and the ring index are 0. No buffer write is issued. Every descriptor word reads 0.
- R2: Register word 1 is the activation register. Writing it with bit 24 set while enabled (word 0 bit 0 = 1) sets the activation state, which reads back on bit 24. While the activation state is 0, an arriving frame causes no buffer write and leaves the descriptor unchanged.
- R3: In an accepted frame, byte k is written to the current descriptor's buffer address plus k, in arrival order.
- R4: Descriptor i occupies word 4+2i, laid out as {status[31:16], length[15:0]}, and word 5+2i, which holds the buffer address. At end of frame, status bit 15 (empty) is cleared, status bit 13 (wrap) is kept, and length becomes the number of bytes stored, FCS included.
- R5: After a frame completes, the ring index advances by one. If the completed descriptor has its wrap bit set, the index returns to 0 instead.
- R6: If the current descriptor's empty bit is 0 when a frame starts, the frame is dropped with no buffer write and the descriptor is left unchanged. The activation state also clears, so later frames are dropped until activation is written again.
- R7: An upstream error flag on the last byte sets status bit 0 and does not set the event bit.
- R8: A frame longer than 1518 bytes sets status bit 5. Only the first 1520 bytes are stored, and the length reads 1520. A frame of exactly 1518 bytes is reported with no error.
- R9: Event register word 2 bit 0 is set when a frame completes with no status error. It stays set until a write with bit 0 = 1; a write with bit 0 = 0 leaves it set.
- R10: Clearing the enable bit returns the ring index to 0 and clears the activation state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| rx_valid | input | 1 | Stream byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Upstream error flag, sampled with rx_eof |
| rx_data | input | 8 | Stream byte |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |

## Verification
The hardest state to reach from the ports is a full ring: the ring index has come back to a descriptor that software has not yet rearmed. To get there, the bench walks frames through every descriptor, past the wrap, and rearms only descriptor 0. The next-but-one frame then meets a software-owned descriptor. The bench checks that this frame is dropped and that activation is cleared. It then rearms the descriptor without reactivating and checks that a further frame is still refused. The oversize case needs a frame longer than the buffer, so that the cap on stored bytes and the length error can both be seen in one writeback.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
// Shared types and field positions for the receive descriptor ring controller.
// Assumes a 16-bit status halfword and a 16-bit length per descriptor.
package rxr_pkg;
    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RECV = 2'd1,
        ENG_DROP = 2'd2
    } eng_state_e;

    localparam int ST_EMPTY  = 15;  // software has handed the buffer over
    localparam int ST_WRAP   = 13;  // last descriptor of the ring
    localparam int ST_LENERR = 5;   // frame exceeded the maximum length
    localparam int ST_RXERR  = 0;   // upstream flagged the frame bad
    localparam int ACT_BIT   = 24;  // activation bit in the kick register
    localparam int LEN_W     = 16;
endpackage

// File: rtl/rxr_desc_mem.sv
`timescale 1ns/1ps
// Descriptor table: status, length and buffer address per entry.
// Assumes engine writeback and software writes never hit the same word
// in one cycle; if they do, the writeback wins.
module rxr_desc_mem #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic [IW-1:0] sw_idx,
    input  logic          sw_word,
    input  logic [31:0]   sw_wdata,
    input  logic [IW-1:0] eng_idx,
    input  logic          wb_en,
    input  logic [15:0]   wb_status,
    input  logic [15:0]   wb_len,
    input  logic [IW-1:0] rd_idx,
    input  logic          rd_word,
    output logic [31:0]   rd_data,
    output logic [15:0]   cur_status,
    output logic [31:0]   cur_buf
);
    logic [15:0] st_q  [N];
    logic [15:0] len_q [N];
    logic [31:0] ba_q  [N];

    // Storage update: engine writeback first, then software access
    always_ff @(posedge clk) begin
        for (int e = 0; e < N; e++) begin
            if (!rst_n) begin
                st_q[e]  <= '0;
                len_q[e] <= '0;
                ba_q[e]  <= '0;
            end else begin
                if (wb_en && eng_idx == IW'(e)) begin
                    st_q[e]  <= wb_status;
                    len_q[e] <= wb_len;
                end else if (sw_we && sw_idx == IW'(e) && !sw_word) begin
                    st_q[e]  <= sw_wdata[31:16];
                    len_q[e] <= sw_wdata[15:0];
                end
                if (sw_we && sw_idx == IW'(e) && sw_word)
                    ba_q[e] <= sw_wdata;
            end
        end
    end

    // Read paths for the engine and the register port
    always_comb begin
        cur_status = st_q[eng_idx];
        cur_buf    = ba_q[eng_idx];
        rd_data    = rd_word ? ba_q[rd_idx] : {st_q[rd_idx], len_q[rd_idx]};
    end
endmodule

// File: rtl/rxr_ctrl_regs.sv
`timescale 1ns/1ps
// Enable, activation and event bits.
// Assumes the decode strobes are mutually exclusive.
module rxr_ctrl_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic sel_ctrl,
    input  logic sel_act,
    input  logic sel_ev,
    input  logic wd_b0,
    input  logic wd_act,
    input  logic drop_clr,
    input  logic ev_set,
    output logic enable_q,
    output logic active_q,
    output logic event_q
);
    // Enable bit written by software
    always_ff @(posedge clk) begin
        if (!rst_n)                enable_q <= 1'b0;
        else if (we && sel_ctrl)   enable_q <= wd_b0;
    end

    // Activation: set by a kick, cleared by a drop or by disable
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_q)          active_q <= 1'b0;
        else if (we && sel_act && wd_act) active_q <= 1'b1;
        else if (drop_clr)                active_q <= 1'b0;
    end

    // Sticky frame event, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n)                       event_q <= 1'b0;
        else if (ev_set)                  event_q <= 1'b1;
        else if (we && sel_ev && wd_b0)   event_q <= 1'b0;
    end
endmodule

// File: rtl/rxr_rx_engine.sv
`timescale 1ns/1ps
// Frame engine: walks the ring, emits buffer writes, builds writeback.
// Assumes well-formed streams (no start marker inside a frame).
module rxr_rx_engine
    import rxr_pkg::*;
#(
    parameter int N         = 4,
    parameter int IW        = 2,
    parameter int MAX_BUF   = 1520,
    parameter int MAX_FRAME = 1518
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          active,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          rx_err,
    input  logic [7:0]    rx_data,
    input  logic [15:0]   cur_status,
    input  logic [31:0]   cur_buf,
    output logic [IW-1:0] idx_q,
    output logic          wb_en,
    output logic [15:0]   wb_status,
    output logic [15:0]   wb_len,
    output logic          drop_clr,
    output logic          ev_set,
    output logic          buf_we,
    output logic [31:0]   buf_addr,
    output logic [7:0]    buf_wdata
);
    localparam int CW = $clog2(MAX_BUF + 1);

    eng_state_e    state_q;
    logic [CW-1:0] cnt_q, cnt_in, cnt_nx;
    logic          ovf_q, ovf_in, ovf_nx;
    logic [31:0]   base_q, base_in;
    logic          accept, take, store, done;
    logic [IW-1:0] idx_nx;

    // Per-beat datapath: acceptance, byte store, length and error tracking
    always_comb begin
        accept   = enable && active && cur_status[ST_EMPTY];
        cnt_in   = (state_q == ENG_IDLE) ? '0 : cnt_q;
        ovf_in   = (state_q == ENG_IDLE) ? 1'b0 : ovf_q;
        base_in  = (state_q == ENG_IDLE) ? cur_buf : base_q;
        take     = enable && rx_valid &&
                   ((state_q == ENG_IDLE && rx_sof && accept) || state_q == ENG_RECV);
        store    = take && (cnt_in < CW'(MAX_BUF));
        cnt_nx   = cnt_in + CW'(store);
        ovf_nx   = ovf_in | (take && cnt_in >= CW'(MAX_FRAME));
        done     = take && rx_eof;
        wb_en    = done;
        wb_status = {1'b0, cur_status[14:6], ovf_nx, 4'b0000, rx_err};
        wb_len   = LEN_W'(cnt_nx);
        ev_set   = done && !ovf_nx && !rx_err;
        drop_clr = enable && active && rx_valid && rx_sof &&
                   state_q == ENG_IDLE && !cur_status[ST_EMPTY];
        idx_nx   = (cur_status[ST_WRAP] || idx_q == IW'(N - 1)) ? '0 : idx_q + IW'(1);
    end

    // Sequencing: state, counters, ring index and registered buffer port
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q   <= ENG_IDLE;
            idx_q     <= '0;
            cnt_q     <= '0;
            ovf_q     <= 1'b0;
            base_q    <= '0;
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_wdata <= '0;
        end else begin
            buf_we <= store;
            if (store) begin
                buf_addr  <= base_in + 32'(cnt_in);
                buf_wdata <= rx_data;
            end
            if (take) begin
                cnt_q  <= cnt_nx;
                ovf_q  <= ovf_nx;
                base_q <= base_in;
            end
            if (done) idx_q <= idx_nx;
            case (state_q)
                ENG_IDLE: if (rx_valid && rx_sof && !rx_eof)
                              state_q <= accept ? ENG_RECV : ENG_DROP;
                ENG_RECV,
                ENG_DROP: if (rx_valid && rx_eof) state_q <= ENG_IDLE;
                default:  state_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxr_ring_ctrl.sv
`timescale 1ns/1ps
// Top of the receive descriptor ring controller: register decode,
// descriptor table, control bits and frame engine.
// Word map: 0 enable, 1 activation, 2 event, 4+2i / 5+2i descriptor i.
module rxr_ring_ctrl #(
    parameter int NUM_DESC        = 4,
    parameter int MAX_BUF_BYTES   = 1520,
    parameter int MAX_FRAME_BYTES = 1518,
    parameter int REG_AW          = $clog2(4 + 2 * NUM_DESC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    input  logic [7:0]        rx_data,
    output logic              buf_we,
    output logic [31:0]       buf_addr,
    output logic [7:0]        buf_wdata
);
    import rxr_pkg::*;

    localparam int IW = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;
    localparam logic [REG_AW-1:0] DESC_LO = REG_AW'(4);
    localparam logic [REG_AW-1:0] DESC_HI = REG_AW'(4 + 2 * NUM_DESC);

    logic [REG_AW-1:0] off;
    logic              d_ok;
    logic [IW-1:0]     d_idx, ring_idx;
    logic [31:0]       mem_rd, cur_buf;
    logic [15:0]       cur_status, wb_status, wb_len;
    logic              wb_en, drop_clr, ev_set;
    logic              enable_q, active_q, event_q;

    // Register address decode
    always_comb begin
        off   = reg_addr - DESC_LO;
        d_ok  = (reg_addr >= DESC_LO) && (reg_addr < DESC_HI);
        d_idx = off[IW:1];
    end

    rxr_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we),
        .sel_ctrl(reg_addr == REG_AW'(0)),
        .sel_act (reg_addr == REG_AW'(1)),
        .sel_ev  (reg_addr == REG_AW'(2)),
        .wd_b0(reg_wdata[0]), .wd_act(reg_wdata[ACT_BIT]),
        .drop_clr(drop_clr), .ev_set(ev_set),
        .enable_q(enable_q), .active_q(active_q), .event_q(event_q)
    );

    rxr_desc_mem #(.N(NUM_DESC), .IW(IW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .sw_we(reg_we && d_ok), .sw_idx(d_idx), .sw_word(off[0]), .sw_wdata(reg_wdata),
        .eng_idx(ring_idx), .wb_en(wb_en), .wb_status(wb_status), .wb_len(wb_len),
        .rd_idx(d_idx), .rd_word(off[0]), .rd_data(mem_rd),
        .cur_status(cur_status), .cur_buf(cur_buf)
    );

    rxr_rx_engine #(.N(NUM_DESC), .IW(IW), .MAX_BUF(MAX_BUF_BYTES),
                    .MAX_FRAME(MAX_FRAME_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n), .enable(enable_q), .active(active_q),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .rx_data(rx_data), .cur_status(cur_status), .cur_buf(cur_buf),
        .idx_q(ring_idx), .wb_en(wb_en), .wb_status(wb_status), .wb_len(wb_len),
        .drop_clr(drop_clr), .ev_set(ev_set),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
    );

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (d_ok) reg_rdata = mem_rd;
        else if (reg_addr == REG_AW'(0)) reg_rdata[0] = enable_q;
        else if (reg_addr == REG_AW'(1)) reg_rdata[ACT_BIT] = active_q;
        else if (reg_addr == REG_AW'(2)) reg_rdata[0] = event_q;
    end
endmodule

// File: rtl/rxr_ring_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for rxr_ring_ctrl, attached by bind.
// Assumes the same word map as the top module.
module rxr_ring_ctrl_chk #(
    parameter int NUM_DESC = 4,
    parameter int IW       = 2,
    parameter int REG_AW   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic              wd_b0,
    input logic              wd_act,
    input logic              buf_we,
    input logic              enable_q,
    input logic              active_q,
    input logic              event_q,
    input logic [IW-1:0]     ring_idx
);
    AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ring_idx) < NUM_DESC);                                           // R5
    AST_DISABLE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_q |=> (ring_idx == '0 && !active_q));                          // R10
    AST_KICK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q && reg_we && reg_addr == REG_AW'(1) && wd_act) |=> active_q); // R2
    AST_NO_WRITE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |=> !buf_we);                                                // R2
    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (event_q && !(reg_we && reg_addr == REG_AW'(2) && wd_b0)) |=> event_q); // R9
endmodule

bind rxr_ring_ctrl rxr_ring_ctrl_chk #(.NUM_DESC(NUM_DESC), .IW(IW), .REG_AW(REG_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .wd_b0(reg_wdata[0]), .wd_act(reg_wdata[24]), .buf_we(buf_we),
    .enable_q(enable_q), .active_q(active_q), .event_q(event_q), .ring_idx(ring_idx)
);

// File: tb/rxr_ring_ctrl_test.sv
`timescale 1ns/1ps
// Directed bench for rxr_ring_ctrl: one task per scenario.
module rxr_ring_ctrl_test;
    localparam int RA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [RA-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          buf_we;
    logic [31:0]   buf_addr;
    logic [7:0]    buf_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    logic [7:0] bmem [0:8191];

    always #10 clk = ~clk;

    rxr_ring_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .rx_data(rx_data), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
    );

    // Bench-side buffer memory and write counter
    always @(posedge clk) begin
        if (buf_we) begin
            bmem[buf_addr[12:0]] <= buf_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = RA'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = RA'(a);
        #1 d = reg_rdata;
    endtask

    task automatic arm(input int i, input bit wrap);
        reg_wr(4 + 2 * i, {(wrap ? 16'hA000 : 16'h8000), 16'h0000});
        reg_wr(5 + 2 * i, 32'(i * 1536));
    endtask

    task automatic send(input int n, input logic [7:0] seed, input bit fe);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_eof = (k == n - 1);
            rx_err = (k == n - 1) ? fe : 1'b0; rx_data = seed + 8'(k);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check_buf(input int base, input int n, input logic [7:0] seed, input string req);
        int bad = 0;
        for (int k = 0; k < n; k++)
            if (bmem[base + k] !== seed + 8'(k)) bad++;
        check(32'(bad), 32'd0, req, "buffer byte mismatches");
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_rd(0, d); check(d, 32'h0, "R1", "enable after reset");
        reg_rd(1, d); check(d, 32'h0, "R1", "activation after reset");
        reg_rd(2, d); check(d, 32'h0, "R1", "event after reset");
        reg_rd(4, d); check(d, 32'h0, "R1", "descriptor 0 after reset");
        check(32'(buf_we), 32'h0, "R1", "buffer write idle after reset");
    endtask

    task automatic t_inactive();
        logic [31:0] d; int w0;
        reg_wr(0, 32'h1);
        for (int i = 0; i < 4; i++) arm(i, i == 3);
        w0 = wr_cnt;
        send(20, 8'h10, 1'b0);
        check(32'(wr_cnt - w0), 32'd0, "R2", "writes before activation");
        reg_rd(4, d); check(d, 32'h8000_0000, "R2", "descriptor 0 untouched");
        reg_rd(1, d); check(d, 32'h0, "R2", "activation still clear");
    endtask

    task automatic t_basic();
        logic [31:0] d; int w0;
        reg_wr(1, 32'h0100_0000);
        reg_rd(1, d); check(d, 32'h0100_0000, "R2", "activation readback");
        w0 = wr_cnt;
        send(64, 8'h30, 1'b0);
        reg_rd(4, d); check(d, 32'h0000_0040, "R4", "descriptor 0 writeback");
        check(32'(wr_cnt - w0), 32'd64, "R3", "byte write count");
        check_buf(0, 64, 8'h30, "R3");
        reg_rd(2, d); check(d, 32'h1, "R9", "event after good frame");
        reg_wr(2, 32'h0);
        reg_rd(2, d); check(d, 32'h1, "R9", "event kept on zero write");
        reg_wr(2, 32'h1);
        reg_rd(2, d); check(d, 32'h0, "R9", "event cleared on one write");
    endtask

    task automatic t_walk();
        logic [31:0] d;
        send(100, 8'h50, 1'b0);
        reg_rd(6, d); check(d, 32'h0000_0064, "R5", "descriptor 1 used next");
        send(10, 8'h70, 1'b0);
        reg_rd(8, d); check(d, 32'h0000_000A, "R5", "descriptor 2 used next");
        send(7, 8'h90, 1'b0);
        reg_rd(10, d); check(d, 32'h2000_0007, "R4", "wrap kept on descriptor 3");
        check_buf(32'h1200, 7, 8'h90, "R3");
        arm(0, 1'b0);
        send(5, 8'hB0, 1'b0);
        reg_rd(4, d); check(d, 32'h0000_0005, "R5", "wrap returns to descriptor 0");
        check_buf(0, 5, 8'hB0, "R3");
    endtask

    task automatic t_full();
        logic [31:0] d; int w0;
        w0 = wr_cnt;
        send(30, 8'hC0, 1'b0);
        check(32'(wr_cnt - w0), 32'd0, "R6", "no writes on owned descriptor");
        reg_rd(6, d); check(d, 32'h0000_0064, "R6", "owned descriptor unchanged");
        reg_rd(1, d); check(d, 32'h0, "R6", "activation cleared by drop");
        arm(1, 1'b0);
        w0 = wr_cnt;
        send(12, 8'hD0, 1'b0);
        check(32'(wr_cnt - w0), 32'd0, "R6", "still dropped until kicked");
        reg_rd(6, d); check(d, 32'h8000_0000, "R6", "rearmed descriptor untouched");
        reg_wr(1, 32'h0100_0000);
        send(12, 8'hD0, 1'b0);
        reg_rd(6, d); check(d, 32'h0000_000C, "R6", "resumes after kick");
    endtask

    task automatic t_err();
        logic [31:0] d;
        reg_wr(2, 32'h1);
        arm(2, 1'b0);
        send(40, 8'hE0, 1'b1);
        reg_rd(8, d); check(d, 32'h0001_0028, "R7", "error flag in status");
        reg_rd(2, d); check(d, 32'h0, "R7", "no event on bad frame");
    endtask

    task automatic t_over();
        logic [31:0] d; int w0;
        arm(3, 1'b1);
        w0 = wr_cnt;
        send(1530, 8'h11, 1'b0);
        reg_rd(10, d); check(d, 32'h2020_05F0, "R8", "oversize status and length");
        check(32'(wr_cnt - w0), 32'd1520, "R8", "stored bytes capped");
        check_buf(32'h1200, 1520, 8'h11, "R8");
        reg_rd(2, d); check(d, 32'h0, "R8", "no event on oversize");
        arm(0, 1'b0);
        send(1518, 8'h22, 1'b0);
        reg_rd(4, d); check(d, 32'h0000_05EE, "R8", "exact maximum accepted");
        reg_rd(2, d); check(d, 32'h1, "R9", "event on maximum frame");
    endtask

    task automatic t_disable();
        logic [31:0] d;
        reg_wr(0, 32'h0);
        reg_rd(1, d); check(d, 32'h0, "R10", "activation cleared by disable");
        reg_wr(0, 32'h1);
        for (int i = 0; i < 4; i++) arm(i, i == 3);
        reg_wr(1, 32'h0100_0000);
        send(9, 8'h33, 1'b0);
        reg_rd(4, d); check(d, 32'h0000_0009, "R10", "ring restarts at descriptor 0");
        reg_rd(6, d); check(d, 32'h8000_0000, "R10", "descriptor 1 still armed");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_inactive();
        t_basic();
        t_walk();
        t_full();
        t_err();
        t_over();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule